// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Saturation Flag

This block is a small arithmetic datapath. It adds or subtracts two signed two's-complement operands and clamps the result to the representable range instead of letting it wrap. It also has a pre-scaling mode. In that mode the second operand is first doubled, with its own saturation, and only then added to or subtracted from the first operand. Both saturation points feed one sticky flag. The flag records that some earlier operation clamped, and it stays set until the surrounding logic clears it explicitly.

The caller presents the primary operand, the secondary operand, the add/subtract select and the doubling select together with a one-cycle valid strobe. One clock later the registered result appears with an output valid. The sticky flag changes on that same edge. Instruction decode and register-file access are left to the caller. Width is a parameter and defaults to 32 bits.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `sub_sel`=0, `dbl_sel`=0 and no overflow, `out_result` equals `op_a + op_b` on the clock edge after `in_valid` is high, and `out_valid` is high for that one cycle.
- R2: With `sub_sel`=1 (subtract), `out_result` equals `op_a - op_b` when that difference is in range.
- R3: When the sum or difference leaves the signed range, `out_result` is the largest positive value (0 followed by all ones) if the exact result is positive, or the most negative value (1 followed by all zeros) if it is negative.
- R4: With `dbl_sel`=1, the secondary operand is replaced by twice its value before the add or subtract.
- R5: If doubling overflows, the doubled operand clamps to the largest positive or most negative value according to the sign of `op_b`, and the add or subtract then proceeds with the clamped value and may saturate again.
- R6: A saturation in either stage during a valid operation sets `sticky_sat` on the same edge that delivers the result. Later operations never clear it.
- R7: `sticky_clr` high on a clock edge clears `sticky_sat`, and it takes priority over a set caused by a saturating operation in the same cycle.
- R8: A cycle with `in_valid` low gives `out_valid` low on the next edge, leaves `out_result` unchanged and leaves `sticky_sat` unchanged unless `sticky_clr` is high.
- R9: After reset, `out_valid`, `out_result` and `sticky_sat` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | W | Primary signed operand |
| op_b | input | W | Secondary signed operand (the one doubled) |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| dbl_sel | input | 1 | 1 = saturating doubling of `op_b` first |
| sticky_clr | input | 1 | Clear of the sticky flag |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | W | Saturated result |
| sticky_sat | output | 1 | Sticky saturation flag |

## Verification
The properties assume that `in_valid`, `sticky_clr` and the operand selects are driven to known values on every clock edge after reset. The holding checks also assume that no input changes at the sampling edge. The bench drives all inputs at the falling edge and keeps them at defined levels from time zero. An exhaustive sweep runs on a 6-bit instance over every operand pair and every mode, so both saturation stages reach both clamp directions. A clear pulse that lands on saturating vectors exercises the priority rule. A 32-bit instance receives directed corner cases at the range limits.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_kind_e;

  localparam int unsigned SAT_W_DEFAULT = 32;
endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
  parameter int unsigned W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // returns {overflow, value}
  function automatic logic [W:0] dbl_sat(input logic [W-1:0] v);
    logic wrap;
    wrap = v[W-1] ^ v[W-2];
    if (wrap) return {1'b1, (v[W-1] ? MINV : MAXV)};
    return {1'b0, v[W-2:0], 1'b0};
  endfunction

  logic [W:0] packed_res;
  assign packed_res = dbl_sat(din);
  assign dout = en ? packed_res[W-1:0] : din;
  assign ovf  = en & packed_res[W];
endmodule

// File: rtl/sat_addsub_core.sv
module sat_addsub_core
  import sat_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // exact result in W+1 bits; range exceeded when the top two bits differ
  function automatic logic [W:0] addsub_sat(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input op_kind_e k);
    logic [W:0] ext;
    if (k == OP_SUB) ext = {x[W-1], x} - {y[W-1], y};
    else             ext = {x[W-1], x} + {y[W-1], y};
    if (ext[W] ^ ext[W-1]) return {1'b1, (ext[W] ? MINV : MAXV)};
    return {1'b0, ext[W-1:0]};
  endfunction

  op_kind_e   kind;
  logic [W:0] packed_res;
  assign kind       = op_kind_e'(sub);
  assign packed_res = addsub_sat(a, b, kind);
  assign res        = packed_res[W-1:0];
  assign ovf        = packed_res[W];
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_pkg::*;
#(
  parameter int unsigned W = SAT_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_sel,
  input  logic         dbl_sel,
  input  logic         sticky_clr,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         sticky_sat
);
  // named internal events, used by the bound checker
  logic [W-1:0] b_scaled;
  logic         dbl_ovf;
  logic [W-1:0] sum_sat;
  logic         sum_ovf;
  logic         sat_event;

  sat_doubler #(.W(W)) u_dbl (
    .en   (dbl_sel),
    .din  (op_b),
    .dout (b_scaled),
    .ovf  (dbl_ovf)
  );

  sat_addsub_core #(.W(W)) u_core (
    .a   (op_a),
    .b   (b_scaled),
    .sub (sub_sel),
    .res (sum_sat),
    .ovf (sum_ovf)
  );

  assign sat_event = in_valid & (dbl_ovf | sum_ovf);

  sat_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sticky_clr),
    .set   (sat_event),
    .flag  (sticky_sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sum_sat;
    end
  end
endmodule

// File: rtl/sat_addsub_checks.sv
module sat_addsub_checks #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         sticky_clr,
  input logic         dbl_ovf,
  input logic         sum_ovf,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         sticky_sat
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_clamp_limits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sum_ovf) |=> (out_result == MAXV || out_result == MINV));

  p_dbl_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dbl_ovf && !sticky_clr) |=> sticky_sat);

  p_sum_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sum_ovf && !sticky_clr) |=> sticky_sat);

  p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_sat && !sticky_clr) |=> sticky_sat);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |=> !sticky_sat);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));

  p_idle_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !sticky_clr) |=> $stable(sticky_sat));
endmodule

bind sat_addsub_unit sat_addsub_checks #(.W(W)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sticky_clr (sticky_clr),
  .dbl_ovf    (dbl_ovf),
  .sum_ovf    (sum_ovf),
  .out_valid  (out_valid),
  .out_result (out_result),
  .sticky_sat (sticky_sat)
);

// File: tb/test_sat_addsub_unit.sv
module test_sat_addsub_unit;
  localparam int SW = 6;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // small instance, swept exhaustively
  logic          s_vin = 0, s_sub = 0, s_dbl = 0, s_clr = 0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic          s_vout, s_sticky;
  logic [SW-1:0] s_res;

  sat_addsub_unit #(.W(SW)) i_sat_addsub_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(s_vin), .op_a(s_a), .op_b(s_b),
    .sub_sel(s_sub), .dbl_sel(s_dbl), .sticky_clr(s_clr),
    .out_valid(s_vout), .out_result(s_res), .sticky_sat(s_sticky));

  // default-width instance, directed corners
  logic          w_vin = 0, w_sub = 0, w_dbl = 0, w_clr = 0;
  logic [LW-1:0] w_a = '0, w_b = '0;
  logic          w_vout, w_sticky;
  logic [LW-1:0] w_res;

  sat_addsub_unit i_sat_addsub_unit_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_vin), .op_a(w_a), .op_b(w_b),
    .sub_sel(w_sub), .dbl_sel(w_dbl), .sticky_clr(w_clr),
    .out_valid(w_vout), .out_result(w_res), .sticky_sat(w_sticky));

  // arithmetic reference in wide integers
  function automatic void ref_op(input int w, input longint a, input longint b,
                                 input bit sub, input bit dbl,
                                 output longint r, output bit dov, output bit sov);
    longint mx, mn, d, s;
    mx = (longint'(1) <<< (w - 1)) - 1;
    mn = -(longint'(1) <<< (w - 1));
    d = b; dov = 0; sov = 0;
    if (dbl) begin
      d = 2 * b;
      if (d > mx) begin d = mx; dov = 1; end
      if (d < mn) begin d = mn; dov = 1; end
    end
    s = sub ? a - d : a + d;
    if (s > mx) begin s = mx; sov = 1; end
    if (s < mn) begin s = mn; sov = 1; end
    r = s;
  endfunction

  function automatic string tag_of(bit sub, bit dbl, bit dov, bit sov);
    if (dov) return "R5";
    if (sov) return "R3";
    if (dbl) return "R4";
    if (sub) return "R2";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  bit s_model_sticky = 0;

  // one operation on the small instance; result checked on the next falling edge
  task automatic s_op(input int a, input int b, input bit sub, input bit dbl, input bit clr);
    longint r; bit dov, sov;
    ref_op(SW, a, b, sub, dbl, r, dov, sov);
    s_a = SW'(a); s_b = SW'(b); s_sub = sub; s_dbl = dbl; s_clr = clr; s_vin = 1;
    @(negedge clk);
    s_vin = 0; s_clr = 0;
    if (clr) s_model_sticky = 0;
    else if (dov || sov) s_model_sticky = 1;
    check(s_vout === 1'b1, "R1", "out_valid", longint'(s_vout), 1);
    check(s_res === SW'(r), tag_of(sub, dbl, dov, sov), "result",
          longint'($signed(s_res)), r);
    check(s_sticky === s_model_sticky, clr ? "R7" : "R6", "sticky",
          longint'(s_sticky), longint'(s_model_sticky));
  endtask

  bit w_model_sticky = 0;

  task automatic w_op(input longint a, input longint b, input bit sub, input bit dbl, input bit clr);
    longint r; bit dov, sov;
    ref_op(LW, a, b, sub, dbl, r, dov, sov);
    w_a = LW'(a); w_b = LW'(b); w_sub = sub; w_dbl = dbl; w_clr = clr; w_vin = 1;
    @(negedge clk);
    w_vin = 0; w_clr = 0;
    if (clr) w_model_sticky = 0;
    else if (dov || sov) w_model_sticky = 1;
    check(w_res === LW'(r), tag_of(sub, dbl, dov, sov), "wide result",
          longint'($signed(w_res)), r);
    check(w_sticky === w_model_sticky, clr ? "R7" : "R6", "wide sticky",
          longint'(w_sticky), longint'(w_model_sticky));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    longint mx32;
    logic [SW-1:0] held;
    int idx;
    mx32 = (longint'(1) <<< 31) - 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check(s_vout === 1'b0, "R9", "out_valid after reset", longint'(s_vout), 0);
    check(s_res === '0, "R9", "result after reset", longint'(s_res), 0);
    check(s_sticky === 1'b0, "R9", "sticky after reset", longint'(s_sticky), 0);
    check(w_res === '0 && w_sticky === 1'b0, "R9", "wide reset", longint'(w_res), 0);

    // exhaustive sweep: R1..R7 across all operand pairs and modes
    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int a = -(1 << (SW - 1)); a < (1 << (SW - 1)); a++) begin
        for (int b = -(1 << (SW - 1)); b < (1 << (SW - 1)); b++) begin
          s_op(a, b, m[0], m[1], (idx % 97) == 0);
          idx++;
        end
      end
    end

    // R7: clear coinciding with a saturating op (doubling of the most positive value)
    s_op((1 << (SW - 1)) - 1, (1 << (SW - 1)) - 1, 0, 1, 1);
    // R6: saturating op then plain ops leave flag set
    s_op(-(1 << (SW - 1)), 1, 1, 0, 0);
    s_op(1, 1, 0, 0, 0);
    s_op(2, 1, 1, 0, 0);

    // R8: idle cycles with operands changing; result, valid and sticky hold
    held = s_res;
    s_a = 6'd5; s_b = 6'd9; s_sub = 1; s_dbl = 1;
    @(negedge clk);
    check(s_vout === 1'b0, "R8", "idle out_valid", longint'(s_vout), 0);
    check(s_res === held, "R8", "idle result hold", longint'(s_res), longint'(held));
    check(s_sticky === 1'b1, "R8", "idle sticky hold", longint'(s_sticky), 1);
    // R7: clear alone while idle
    s_clr = 1;
    @(negedge clk);
    s_clr = 0;
    check(s_sticky === 1'b0, "R7", "idle clear", longint'(s_sticky), 0);
    check(s_res === held, "R8", "result hold through clear", longint'(s_res), longint'(held));

    // wide instance directed corners
    w_op(5, 7, 0, 0, 0);                       // R1
    w_op(5, 7, 1, 0, 0);                       // R2
    w_op(mx32, 1, 0, 0, 0);                    // R3 positive clamp
    w_op(-mx32 - 1, 1, 1, 0, 0);               // R3 negative clamp
    w_op(0, 0, 0, 0, 1);                       // R7 clear
    w_op(100, 1000, 0, 1, 0);                  // R4
    w_op(0, 64'sh40000000, 0, 1, 0);           // R5 positive doubling clamp
    w_op(-1, 64'sh40000000, 1, 1, 1);          // R5 clamp, exact MIN, clear
    w_op(1, -64'sh40000001, 0, 1, 0);          // R5 negative doubling clamp
    w_op(-mx32 - 1, -mx32 - 1, 0, 1, 0);       // R5 then R3

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule